// File: doc/BRIEF.md
# Transform Mode Configuration Manager

This block sits between the logic that delivers a per-subcarrier bit allocation vector and an FFT engine that can run either a full radix-2 transform or a sparse transform that computes only the active outputs. The vector streams in one entry per cycle. Each entry gives the number of bits loaded on one subcarrier, and an entry of zero marks a subcarrier that is switched off. While the vector arrives, the block counts the active subcarriers (L). It also stores the position of each active subcarrier in a small index memory.

When the last entry has been taken, the block chooses the transform. The sparse variant is picked when L is below half the subcarrier count, and the radix-2 variant otherwise. For the sparse case the block derives the power-of-two decomposition sizes N1 and N2. It then sends a configuration record to the engine as a sequence of words over a valid/ready channel. After the last word it stays in standby until a new vector begins.

Top module: `xcfg_manager`

## Requirements
- R1: While reset is held and right after it is released, `cfg_valid` is low.
- R2: The word L equals the number of non-zero `in_bits` values among the accepted entries. Cycles with `in_valid` low do not count, whatever `in_bits` holds. Entries beyond the NUM_SC-th position of a vector do not count.
- R3: The first word of a record is the mode code. It is 1 (sparse) when L < NUM_SC/2 and 0 (radix-2) otherwise, zero-extended to the data width.
- R4: In sparse mode, N1 is the smallest power of two strictly larger than L, and N2 = NUM_SC/N1. In radix-2 mode, N1 = NUM_SC and N2 = 1.
- R5: The words of a record come in the order mode, L, N1, N2, then the index list. Each word stays on `cfg_data` and `cfg_last`, with `cfg_valid` high, until a cycle in which `cfg_ready` is high.
- R6: The index list is sent only in sparse mode with L > 0. It holds L words in ascending order. Each word is the zero-based position of an active entry, counted from the entry flagged `in_first`.
- R7: `cfg_last` is high on the final word of a record and low on every other word.
- R8: A vector with no active entry gives mode 1, L = 0, N1 = 1, N2 = NUM_SC, and no index list, so `cfg_last` comes with N2.
- R9: After the final word has been accepted, no word is offered until a new vector starts with an entry flagged `in_first`. Input presented while a record is being sent is ignored, including in the cycle in which the final word is accepted.
- R10: An entry flagged `in_first` that arrives while a vector is loading discards the partial count and index list and starts a new vector at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Allocation entry present |
| in_first | input | 1 | Entry is position 0 of a new vector |
| in_last | input | 1 | Entry is the final one of the vector |
| in_bits | input | BITS_W | Bits loaded on this subcarrier; 0 means the subcarrier is off |
| cfg_valid | output | 1 | Configuration word offered |
| cfg_ready | input | 1 | Engine accepts the offered word |
| cfg_data | output | CNT_W | Configuration word (mode, L, N1, N2 or an index) |
| cfg_last | output | 1 | Final word of the record |

## Verification
The record handshake and the input port can be active in the same cycle: a new vector may start in exactly the cycle the engine accepts the final word. The bench provokes this by driving a one-entry vector, flagged both first and last, in the cycle that the final word is taken. It also drives such a vector in the middle of a record. In both cases a wrongly accepted vector would produce a second record, so the bench judges the outcome by watching `cfg_valid` stay low for several cycles afterwards. It then confirms that a properly started vector still yields the expected record.

// File: rtl/cfgmgr_pkg.sv
package cfgmgr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_MODE,
        ST_COUNT,
        ST_N1,
        ST_N2,
        ST_IDX
    } cfg_state_e;

    localparam logic MODE_RADIX2 = 1'b0;
    localparam logic MODE_SPARSE = 1'b1;

endpackage

// File: rtl/cfgmgr_split.sv
// Derives the transform variant and the decomposition sizes from the active count.
module cfgmgr_split #(
    parameter int NUM_SC = 512,
    parameter int CNT_W  = 10
) (
    input  logic [CNT_W-1:0] act_cnt_i,
    output logic             sparse_o,
    output logic [CNT_W-1:0] n1_o,
    output logic [CNT_W-1:0] n2_o
);

    localparam logic [CNT_W-1:0] HALF_C = CNT_W'(NUM_SC / 2);
    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(NUM_SC);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    int top_i;

    always_comb begin
        // Bit length of the count gives the shift for the next power of two above it
        top_i = 0;
        for (int b = 0; b < CNT_W; b++) begin
            if (act_cnt_i[b]) top_i = b + 1;
        end
        sparse_o = (act_cnt_i < HALF_C);
        if (sparse_o) begin
            n1_o = ONE_C << top_i;
            n2_o = FULL_C >> top_i;
        end else begin
            n1_o = FULL_C;
            n2_o = ONE_C;
        end
    end

endmodule

// File: rtl/cfgmgr_idx_store.sv
// Holds the active positions of the current vector, one per slot.
module cfgmgr_idx_store #(
    parameter int DEPTH = 256,
    parameter int AW    = 8,
    parameter int DW    = 9
) (
    input  logic          clk,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o
);

    logic [DW-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) slot_q[wr_addr_i] <= wr_data_i;
    end

    assign rd_data_o = slot_q[rd_addr_i];

endmodule

// File: rtl/xcfg_manager.sv
module xcfg_manager
    import cfgmgr_pkg::*;
#(
    parameter int NUM_SC = 512,
    parameter int BITS_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        in_first,
    input  logic                        in_last,
    input  logic [BITS_W-1:0]           in_bits,
    output logic                        cfg_valid,
    input  logic                        cfg_ready,
    output logic [$clog2(NUM_SC):0]     cfg_data,
    output logic                        cfg_last
);

    localparam int IDX_W      = $clog2(NUM_SC);
    localparam int CNT_W      = IDX_W + 1;
    localparam int LIST_DEPTH = NUM_SC / 2;
    localparam int LIST_AW    = $clog2(LIST_DEPTH);
    localparam logic [CNT_W-1:0] NUM_SC_C = CNT_W'(NUM_SC);
    localparam logic [CNT_W-1:0] LIST_C   = CNT_W'(LIST_DEPTH);
    localparam logic [CNT_W-1:0] ONE_C    = CNT_W'(1);

    typedef struct packed {
        cfg_state_e       st;
        logic [CNT_W-1:0] pos;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rd;
    } regs_t;

    regs_t q, d;

    logic               sparse_w;
    logic [CNT_W-1:0]   n1_w, n2_w;
    logic               wr_en_w;
    logic [LIST_AW-1:0] wr_addr_w;
    logic [IDX_W-1:0]   wr_data_w;
    logic [IDX_W-1:0]   rd_data_w;
    logic               take_in_w;
    logic               fire_w;
    logic               has_list_w;
    logic               list_end_w;
    logic [CNT_W-1:0]   base_pos_w, base_cnt_w;

    cfgmgr_split #(.NUM_SC(NUM_SC), .CNT_W(CNT_W)) split_i (
        .act_cnt_i (q.cnt),
        .sparse_o  (sparse_w),
        .n1_o      (n1_w),
        .n2_o      (n2_w)
    );

    cfgmgr_idx_store #(.DEPTH(LIST_DEPTH), .AW(LIST_AW), .DW(IDX_W)) store_i (
        .clk       (clk),
        .wr_en_i   (wr_en_w),
        .wr_addr_i (wr_addr_w),
        .wr_data_i (wr_data_w),
        .rd_addr_i (q.rd[LIST_AW-1:0]),
        .rd_data_o (rd_data_w)
    );

    // Output word selection
    always_comb begin
        has_list_w = sparse_w && (q.cnt != '0);
        list_end_w = (q.rd == q.cnt - ONE_C);
        cfg_valid  = 1'b0;
        cfg_data   = '0;
        cfg_last   = 1'b0;
        unique case (q.st)
            ST_MODE: begin
                cfg_valid = 1'b1;
                cfg_data  = {{(CNT_W-1){1'b0}}, sparse_w};
            end
            ST_COUNT: begin
                cfg_valid = 1'b1;
                cfg_data  = q.cnt;
            end
            ST_N1: begin
                cfg_valid = 1'b1;
                cfg_data  = n1_w;
            end
            ST_N2: begin
                cfg_valid = 1'b1;
                cfg_data  = n2_w;
                cfg_last  = !has_list_w;
            end
            ST_IDX: begin
                cfg_valid = 1'b1;
                cfg_data  = {1'b0, rd_data_w};
                cfg_last  = list_end_w;
            end
            default: ;
        endcase
        fire_w = cfg_valid && cfg_ready;
    end

    // Next-state logic
    always_comb begin
        d          = q;
        wr_en_w    = 1'b0;
        wr_addr_w  = '0;
        wr_data_w  = '0;
        take_in_w  = in_valid && (((q.st == ST_IDLE) && in_first) || (q.st == ST_LOAD));
        base_pos_w = in_first ? '0 : q.pos;
        base_cnt_w = in_first ? '0 : q.cnt;

        if (take_in_w) begin
            d.pos = base_pos_w;
            d.cnt = base_cnt_w;
            if (base_pos_w < NUM_SC_C) begin
                d.pos = base_pos_w + ONE_C;
                if (in_bits != '0) begin
                    d.cnt = base_cnt_w + ONE_C;
                    if (base_cnt_w < LIST_C) begin
                        wr_en_w   = 1'b1;
                        wr_addr_w = base_cnt_w[LIST_AW-1:0];
                        wr_data_w = base_pos_w[IDX_W-1:0];
                    end
                end
            end
            d.st = in_last ? ST_MODE : ST_LOAD;
        end

        unique case (q.st)
            ST_MODE:  if (fire_w) d.st = ST_COUNT;
            ST_COUNT: if (fire_w) d.st = ST_N1;
            ST_N1:    if (fire_w) d.st = ST_N2;
            ST_N2: begin
                if (fire_w) begin
                    d.rd = '0;
                    d.st = has_list_w ? ST_IDX : ST_IDLE;
                end
            end
            ST_IDX: begin
                if (fire_w) begin
                    if (list_end_w) d.st = ST_IDLE;
                    else            d.rd = q.rd + ONE_C;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st  <= ST_IDLE;
            q.pos <= '0;
            q.cnt <= '0;
            q.rd  <= '0;
        end else begin
            q <= d;
        end
    end

    AST_HOLD_ITEM: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_data) && $stable(cfg_last)); // R5

    AST_QUIET_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_ready && cfg_last |=> !cfg_valid); // R9

    AST_SPLIT_TIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_N1) && sparse_w |-> (n1_w > q.cnt) && ((n1_w == ONE_C) || ((n1_w >> 1) <= q.cnt))); // R4

    AST_SPLIT_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (32'(n1_w) * 32'(n2_w)) == 32'(NUM_SC)); // R4

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= q.pos); // R2

    AST_LIST_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDX) && fire_w && !cfg_last |=> cfg_data > $past(cfg_data)); // R6

endmodule

// File: tb/xcfg_manager_tb_top.sv
module xcfg_manager_tb_top;

    localparam int NSC = 512;
    localparam int DW  = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, in_first, in_last;
    logic [3:0]    in_bits;
    logic          cfg_valid, cfg_ready, cfg_last;
    logic [DW-1:0] cfg_data;

    int checks = 0;
    int errors = 0;

    logic [3:0] vec [NSC];
    int         exp_w [600];
    int         exp_n;
    int         got_w [600];
    bit         got_l [600];
    int         got_n;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    xcfg_manager #(.NUM_SC(NSC), .BITS_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .in_bits(in_bits), .cfg_valid(cfg_valid),
        .cfg_ready(cfg_ready), .cfg_data(cfg_data), .cfg_last(cfg_last)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(20 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    // kind: 0 zeros, 1 dense, 2 sparse, 3 odd<510, 4 all odd, 5 only 511, 6 gapped
    task automatic set_vec(input int kind);
        for (int i = 0; i < NSC; i++) begin
            case (kind)
                1: vec[i] = (i % 6 != 0) ? 4'(1 + i % 4) : 4'd0;
                2: vec[i] = (i % 9 == 4) ? 4'd6 : 4'd0;
                3: vec[i] = (i % 2 == 1 && i < 510) ? 4'd2 : 4'd0;
                4: vec[i] = (i % 2 == 1) ? 4'd3 : 4'd0;
                5: vec[i] = (i == 511) ? 4'd8 : 4'd0;
                6: vec[i] = (i % 50 == 7) ? 4'd4 : 4'd0;
                7: vec[i] = (i == 3 || i == 200 || i == 201) ? 4'd1 : 4'd0;
                8: vec[i] = (i == 10 || i == 20 || i == 30 || i == 40 || i == 499) ? 4'd5 : 4'd0;
                9: vec[i] = (i == 0 || i == 300) ? 4'd2 : 4'd0;
                default: vec[i] = 4'd0;
            endcase
        end
    endtask

    task automatic build_expect();
        int l = 0;
        int p = 1;
        for (int i = 0; i < NSC; i++) if (vec[i] != 0) l++;
        exp_w[1] = l;
        if (l < NSC / 2) begin
            exp_w[0] = 1;
            while (p <= l) p = p * 2;
            exp_w[2] = p;
            exp_w[3] = NSC / p;
            exp_n = 4;
            for (int i = 0; i < NSC; i++) if (vec[i] != 0) begin exp_w[exp_n] = i; exp_n++; end
        end else begin
            exp_w[0] = 0;
            exp_w[2] = NSC;
            exp_w[3] = 1;
            exp_n = 4;
        end
    endtask

    // gap: insert an idle cycle with junk bits before every gap-th entry
    task automatic send_vec(input int count, input bit with_last, input int gap);
        for (int i = 0; i < count; i++) begin
            if (gap > 0 && i % gap == 0) begin
                @(negedge clk);
                in_valid = 1'b0; in_first = (i == 0); in_last = 1'b1; in_bits = 4'hF;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_first = (i == 0);
            in_last  = with_last && (i == count - 1);
            in_bits  = vec[i];
        end
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_bits = 4'd0;
    endtask

    // inject: 1 = one-entry vector during record, 2 = same in final accept cycle
    task automatic collect(input bit full_ready, input int inject);
        int  cyc = 0;
        bit  done = 0;
        bit  hold = 0;
        bit  inj = 0;
        int  hold_bad = 0;
        int  quiet_bad = 0;
        logic [DW-1:0] hd;
        logic hl;
        bit  rdy;
        got_n = 0;
        while (!done && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (inj) begin
                in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_bits = 4'd0; inj = 0;
            end
            if (hold && (!cfg_valid || cfg_data != hd || cfg_last != hl)) hold_bad++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rdy = full_ready ? 1'b1 : (lfsr[0] | lfsr[2]);
            cfg_ready = rdy;
            if (cfg_valid && rdy) begin
                got_w[got_n] = int'(cfg_data);
                got_l[got_n] = cfg_last;
                got_n++;
                hold = 0;
                if (cfg_last) done = 1;
                if ((inject == 2 && cfg_last) || (inject == 1 && got_n == 2)) begin
                    in_valid = 1'b1; in_first = 1'b1; in_last = 1'b1; in_bits = 4'd7; inj = 1;
                end
            end else if (cfg_valid) begin
                hold = 1; hd = cfg_data; hl = cfg_last;
            end
        end
        @(negedge clk);
        cfg_ready = 1'b0;
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_bits = 4'd0;
        chk(cyc < 4000, "R5 record completes", cyc, 4000);
        chk(hold_bad == 0, "R5 word held until ready", hold_bad, 0);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (cfg_valid) quiet_bad++;
        end
        chk(quiet_bad == 0, "R9 standby after record", quiet_bad, 0);
    endtask

    task automatic compare();
        int bad_idx = 0;
        int bad_last = 0;
        chk(got_n == exp_n, "R5 R6 word count", got_n, exp_n);
        chk(got_w[0] == exp_w[0], "R3 mode word", got_w[0], exp_w[0]);
        chk(got_w[1] == exp_w[1], "R2 active count", got_w[1], exp_w[1]);
        chk(got_w[2] == exp_w[2], "R4 N1", got_w[2], exp_w[2]);
        chk(got_w[3] == exp_w[3], "R4 N2", got_w[3], exp_w[3]);
        for (int i = 4; i < exp_n && i < got_n; i++) if (got_w[i] != exp_w[i]) bad_idx++;
        chk(bad_idx == 0, "R6 index list", bad_idx, 0);
        for (int i = 0; i < got_n; i++) if (got_l[i] != (i == got_n - 1)) bad_last++;
        chk(bad_last == 0, "R7 last flag placement", bad_last, 0);
    endtask

    task automatic run_case(input int kind, input bit full_ready, input int gap, input int inject);
        set_vec(kind);
        build_expect();
        send_vec(NSC, 1'b1, gap);
        collect(full_ready, inject);
        compare();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
        in_bits = 4'd0; cfg_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk(cfg_valid == 1'b0, "R1 idle in reset", int'(cfg_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_valid == 1'b0, "R1 idle after reset", int'(cfg_valid), 0);
    endtask

    task automatic t_zero();
        run_case(0, 1'b0, 0, 0);
        chk(got_n == 4 && got_w[2] == 1 && got_w[3] == NSC && got_l[3],
            "R8 empty vector record", got_w[2], 1);
    endtask

    task automatic t_restart();
        for (int i = 0; i < NSC; i++) vec[i] = 4'hF;
        send_vec(100, 1'b0, 0);
        set_vec(7);
        build_expect();
        send_vec(NSC, 1'b1, 0);
        collect(1'b1, 0);
        compare();
        chk(got_w[1] == 3, "R10 restart discards partial", got_w[1], 3);
    endtask

    task automatic t_stray();
        @(negedge clk);
        in_valid = 1'b1; in_first = 1'b0; in_last = 1'b1; in_bits = 4'd9;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_bits = 4'd0;
        cfg_ready = 1'b1;
        repeat (4) @(negedge clk);
        chk(cfg_valid == 1'b0, "R9 standby needs first flag", int'(cfg_valid), 0);
        cfg_ready = 1'b0;
    endtask

    initial begin
        t_reset();
        run_case(1, 1'b0, 0, 0);   // R3 radix-2, dense
        run_case(2, 1'b0, 0, 0);   // R6 sparse list
        t_zero();                  // R8
        run_case(3, 1'b1, 0, 0);   // R3 R4 L = NUM_SC/2 - 1
        run_case(4, 1'b0, 0, 0);   // R3 L = NUM_SC/2
        run_case(5, 1'b1, 0, 0);   // R4 L = 1 at final position
        run_case(6, 1'b0, 5, 0);   // R2 idle cycles with junk bits
        t_restart();               // R10
        run_case(8, 1'b0, 0, 1);   // R9 input during record
        run_case(9, 1'b1, 0, 2);   // R9 input in final accept cycle
        t_stray();                 // R9
        run_case(2, 1'b1, 0, 0);   // recovery after ignored inputs
        summary();
        $finish;
    end

endmodule